// File: doc/BRIEF.md
# SPI Register Access Slave

This block connects a four-wire SPI host to a byte-wide register file inside the chip. The host pulls the active-low select low and clocks in a command byte. The top bit of that byte gives the direction and the remaining seven bits give the starting register. After the command comes any number of data bytes. The block turns each incoming byte into a single-cycle write strobe on a parallel register bus. For reads, it fetches each register with a single-cycle read strobe and shifts the value back out on MISO. In both directions the address advances by one after every data byte, so a burst walks through consecutive registers.

The serial pins are not used as clocks. SCLK, select and MOSI are all synchronised into the system clock domain, and the block finds SCLK edges by comparing successive synchronised samples. It captures MOSI on a rising SCLK edge and updates MISO on a falling SCLK edge, which matches SPI mode 0 with the clock idling low. MISO has its own output-enable, and that enable is low whenever select is high.

Top module: `spi_regbus_slave`

## Requirements
- R1: After reset, and whenever `spi_csn` has been high for more than SYNC_STAGES clock cycles, `spi_miso_oe` is 0. While select is low, `spi_miso_oe` is 1.
- R2: Bytes are 8 bits, most significant bit first. A data byte is written with `reg_wr` high in the cycle that starts SYNC_STAGES+2 clock edges after the SCLK rising edge that carries its last bit. A read of the command's address starts with `reg_rd` high at that same distance after the command's last bit.
- R3: If bit 7 of the command byte is 0, the command selects a write to address bits [6:0]. The first data byte that follows gives exactly one `reg_wr` pulse, with `reg_addr` equal to that address and `reg_wdata` equal to the byte.
- R4: In a write burst, data byte k (counting from 0) goes to the start address plus k, modulo 128.
- R5: If bit 7 of the command byte is 1, the command selects a read. `reg_rd` pulses with `reg_addr` set to the command's address. The value on `reg_rdata` in that cycle is shifted out on MISO, MSB first, during the next byte, and the host samples each bit on a rising SCLK edge.
- R6: In a read burst, data byte k returns the register at the start address plus k, modulo 128. Each completed data byte is followed by one more `reg_rd` for the next address, including after the last byte.
- R7: If select rises partway through a byte, that byte is dropped and no strobe is issued for it. The next transaction decodes normally.
- R8: `reg_wr` and `reg_rd` each last exactly one cycle, are never high together, and neither is high once select has been high for more than SYNC_STAGES+2 cycles. `reg_addr` changes only in a cycle in which a strobe is issued.
- R9: A transaction that carries only a write command byte issues no `reg_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | SPI select, active low |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for MISO pad, low means high-impedance |
| reg_addr | output | 7 | Register address for the current strobe |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Read data, sampled in the cycle reg_rd is high |

## Verification
Each strobe is due SYNC_STAGES+2 clock edges after the SCLK rising edge that carries the last bit of its byte: two of those edges are the synchroniser, one is the byte register and one is the strobe register. The bench counts clock edges from the moment it drives that SCLK edge. A monitor records every strobe with its cycle number, and the bench compares the recorded distance against that figure. MISO bits are read just before the bench raises SCLK. By that point the falling edge that shifted them has long passed through the synchroniser, because each SCLK phase lasts eight system clocks.

// File: rtl/spi_regbus_pkg.sv
package spi_regbus_pkg;
   typedef enum logic {
      PH_CMD  = 1'b0,
      PH_DATA = 1'b1
   } phase_t;

   typedef enum logic {
      DIR_WR = 1'b0,
      DIR_RD = 1'b1
   } dir_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_bit_rx.sv
module spi_bit_rx #(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              sclk_s,
   input  logic              mosi_s,
   output logic              sclk_fall,
   output logic [CNT_W-1:0]  bit_idx,
   output logic              byte_vld,
   output logic [DATA_W-1:0] byte_q
);
   logic              sclk_d;
   logic              sclk_rise;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] next_sh;

   assign sclk_rise = active &  sclk_s & ~sclk_d;
   assign sclk_fall = active & ~sclk_s &  sclk_d;
   assign next_sh   = {shreg[DATA_W-2:0], mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         bit_idx  <= '0;
         shreg    <= '0;
         byte_vld <= 1'b0;
         byte_q   <= '0;
      end else begin
         sclk_d   <= sclk_s;
         byte_vld <= 1'b0;
         if (!active) begin
            bit_idx <= '0;
            shreg   <= '0;
         end else if (sclk_rise) begin
            shreg <= next_sh;
            if (bit_idx == CNT_W'(DATA_W-1)) begin
               bit_idx  <= '0;
               byte_vld <= 1'b1;
               byte_q   <= next_sh;
            end else begin
               bit_idx <= bit_idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spi_bit_tx.sv
module spi_bit_tx #(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              sclk_fall,
   input  logic [CNT_W-1:0]  bit_idx,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic              miso
);
   logic [DATA_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0;
      end else if (!active) begin
         sr <= '0;
      end else if (load) begin
         sr <= load_data;
      end else if (sclk_fall && bit_idx != '0) begin
         sr <= {sr[DATA_W-2:0], 1'b0};
      end
   end

   assign miso = sr[DATA_W-1];
endmodule

// File: rtl/spi_regbus_slave.sv
module spi_regbus_slave
   import spi_regbus_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   localparam int ADDR_W     = DATA_W - 1,
   localparam int CNT_W      = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_csn,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   input  logic [DATA_W-1:0] reg_rdata
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 4) begin : g_bad_width
         $error("DATA_W must be at least 4");
      end
   endgenerate

   logic              csn_s, sclk_s, mosi_s, active;
   logic              sclk_fall, byte_vld;
   logic [CNT_W-1:0]  bit_idx;
   logic [DATA_W-1:0] byte_q;
   phase_t            phase;
   dir_t              dir;
   logic [ADDR_W-1:0] addr_q;

   spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
      .clk(clk), .rst_n(rst_n), .d(spi_csn), .q(csn_s));
   spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(spi_sclk), .q(sclk_s));
   spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(mosi_s));

   assign active = ~csn_s;

   spi_bit_rx #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .active(active),
      .sclk_s(sclk_s), .mosi_s(mosi_s),
      .sclk_fall(sclk_fall), .bit_idx(bit_idx),
      .byte_vld(byte_vld), .byte_q(byte_q));

   spi_bit_tx #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .active(active),
      .sclk_fall(sclk_fall), .bit_idx(bit_idx),
      .load(reg_rd), .load_data(reg_rdata),
      .miso(spi_miso));

   assign spi_miso_oe = active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_CMD;
         dir       <= DIR_WR;
         addr_q    <= '0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         reg_wr    <= 1'b0;
         reg_rd    <= 1'b0;
      end else begin
         reg_wr <= 1'b0;
         reg_rd <= 1'b0;
         if (!active) begin
            phase <= PH_CMD;
         end else if (byte_vld) begin
            if (phase == PH_CMD) begin
               phase  <= PH_DATA;
               dir    <= dir_t'(byte_q[DATA_W-1]);
               addr_q <= byte_q[ADDR_W-1:0];
               if (byte_q[DATA_W-1] == DIR_RD) begin
                  reg_rd   <= 1'b1;
                  reg_addr <= byte_q[ADDR_W-1:0];
               end
            end else if (dir == DIR_WR) begin
               reg_wr    <= 1'b1;
               reg_addr  <= addr_q;
               reg_wdata <= byte_q;
               addr_q    <= addr_q + 1'b1;
            end else begin
               reg_rd   <= 1'b1;
               reg_addr <= addr_q + 1'b1;
               addr_q   <= addr_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spi_regbus_slave_chk.sv
module spi_regbus_slave_chk #(
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   localparam int ADDR_W     = DATA_W - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              spi_csn,
   input logic              spi_miso_oe,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              reg_rd
);
   localparam int LIM = SYNC_STAGES + 3;
   int hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_cnt <= 0;
      else if (!spi_csn) hi_cnt <= 0;
      else if (hi_cnt < LIM) hi_cnt <= hi_cnt + 1;
   end

   // R1
   idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt > SYNC_STAGES) |-> !spi_miso_oe);
   // R8
   excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));
   // R8
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);
   // R8
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);
   // R8
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt > SYNC_STAGES + 2) |-> (!reg_wr && !reg_rd));
   // R8
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != $past(reg_addr)) |-> (reg_wr || reg_rd));
endmodule

bind spi_regbus_slave spi_regbus_slave_chk #(
   .SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_miso_oe(spi_miso_oe),
   .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd));

// File: tb/spi_regbus_slave_bench.sv
module spi_regbus_slave_bench;
   localparam int SYNC = 2;
   localparam int HALF = 8;
   localparam int LAT  = SYNC + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csn = 1'b1, sclk = 1'b0, mosi = 1'b0;
   logic miso, miso_oe, reg_wr, reg_rd;
   logic [6:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;

   int checks = 0, errors = 0, cyc = 0, rise_cyc = 0;
   int wn = 0, rn = 0, both = 0;
   logic [6:0] wa [0:511];
   logic [7:0] wd [0:511];
   int         wc [0:511];
   logic [6:0] ra [0:511];
   int         rc [0:511];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] rmodel(input logic [6:0] a);
      return 8'(a * 8'd37 + 8'd11);
   endfunction
   assign reg_rdata = rmodel(reg_addr);

   spi_regbus_slave #(.SYNC_STAGES(SYNC)) u_spi_regbus_slave (
      .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk),
      .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_rdata(reg_rdata));

   always @(negedge clk) begin
      if (reg_wr && reg_rd) both++;
      if (reg_wr && wn < 512) begin
         wa[wn] = reg_addr; wd[wn] = reg_wdata; wc[wn] = cyc; wn++;
      end
      if (reg_rd && rn < 512) begin
         ra[rn] = reg_addr; rc[rn] = cyc; rn++;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cs_low();
      @(negedge clk); csn = 1'b0; wait_n(HALF);
   endtask

   task automatic cs_high();
      wait_n(HALF); csn = 1'b1; wait_n(3 * HALF);
   endtask

   task automatic xfer_bits(input logic [7:0] tx, input int nbits,
                            output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
         mosi = tx[i];
         wait_n(HALF);
         rx[i] = miso;
         sclk = 1'b1; rise_cyc = cyc;
         wait_n(HALF);
         sclk = 1'b0;
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      xfer_bits(tx, 8, rx);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] rx;
      int w0, r0;
      wait_n(3);
      // R1 reset state
      check("R1 reset oe", int'(miso_oe), 0);
      check("R8 reset strobes", int'(reg_wr | reg_rd), 0);
      rst_n = 1'b1;
      wait_n(4);
      check("R1 idle oe", int'(miso_oe), 0);

      // R3 R2 single write to every address
      for (int a = 0; a < 128; a++) begin
         w0 = wn;
         cs_low();
         check("R1 oe while selected", int'(miso_oe), 1);
         xfer({1'b0, 7'(a)}, rx);
         xfer(8'(a * 13 + 7), rx);
         wait_n(LAT + 2);
         check("R3 write count", wn - w0, 1);
         check("R3 write addr", int'(wa[w0]), a);
         check("R2 write data msb first", int'(wd[w0]), (a * 13 + 7) & 255);
         check("R2 write latency", wc[w0] - rise_cyc, LAT);
         cs_high();
         check("R1 oe after release", int'(miso_oe), 0);
      end

      // R9 command byte only
      w0 = wn;
      cs_low(); xfer(8'h15, rx); cs_high();
      check("R9 no write for bare command", wn - w0, 0);

      // R4 burst write with wrap
      w0 = wn;
      cs_low();
      xfer({1'b0, 7'h7C}, rx);
      for (int k = 0; k < 8; k++) xfer(8'(8'hC0 + k), rx);
      cs_high();
      check("R4 burst count", wn - w0, 8);
      for (int k = 0; k < 8; k++) begin
         check("R4 burst addr", int'(wa[w0 + k]), (8'h7C + k) & 127);
         check("R4 burst data", int'(wd[w0 + k]), 8'hC0 + k);
      end

      // R7 partial data byte dropped
      w0 = wn;
      cs_low();
      xfer({1'b0, 7'h22}, rx);
      xfer(8'h9D, rx);
      xfer_bits(8'hFF, 5, rx);
      cs_high();
      check("R7 partial byte count", wn - w0, 1);
      check("R7 full byte data", int'(wd[w0]), 8'h9D);
      // R7 partial command then clean write
      w0 = wn; r0 = rn;
      cs_low(); xfer_bits(8'hFF, 3, rx); cs_high();
      check("R7 partial command no strobe", (wn - w0) + (rn - r0), 0);
      cs_low(); xfer({1'b0, 7'h41}, rx); xfer(8'h6E, rx); cs_high();
      check("R7 next write count", wn - w0, 1);
      check("R7 next write addr", int'(wa[w0]), 8'h41);
      check("R7 next write data", int'(wd[w0]), 8'h6E);

      // R5 single reads
      for (int a = 0; a < 128; a += 4) begin
         r0 = rn;
         cs_low();
         xfer({1'b1, 7'(a)}, rx);
         wait_n(LAT + 2);
         check("R5 first read addr", int'(ra[r0]), a);
         check("R2 read latency", rc[r0] - rise_cyc, LAT);
         xfer(8'h00, rx);
         check("R5 miso data", int'(rx), int'(rmodel(7'(a))));
         cs_high();
         check("R6 read strobe count", rn - r0, 2);
      end

      // R6 burst read with wrap
      r0 = rn;
      cs_low();
      xfer({1'b1, 7'h7E}, rx);
      for (int k = 0; k < 5; k++) begin
         xfer(8'hA5, rx);
         check("R6 burst read data", int'(rx), int'(rmodel(7'(8'h7E + k))));
      end
      cs_high();
      check("R6 burst strobe count", rn - r0, 6);
      for (int k = 0; k < 6; k++)
         check("R6 burst read addr", int'(ra[r0 + k]), (8'h7E + k) & 127);

      check("R8 strobes exclusive", both, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule